// File: doc/BRIEF.md
# Byte-Stream Frame Checker

This block collects a stream of bytes, one per accepted transfer, into a fixed-length frame. A frame has three parts: a header, a payload, and a trailing check field. While the header arrives, a running XOR of its bytes is built up. When the final byte of the frame is taken, that XOR is compared against the low byte of the check field. A frame whose check matches is presented whole on a parallel output under a valid/ready handshake. A frame whose check fails produces a one-cycle error pulse and is dropped.

Collection of the next frame is not held up by the checker. The next frame can start in the same cycle that the error pulse is shown, or in the cycle where the previous good frame is taken by the consumer. Input is stalled only while a good frame is waiting at the output and the consumer is not ready.

Top module: `frame_checker`

## Requirements
- R1: After a synchronous reset, inReady is 1 and outValid and badPulse are 0. A reset in the middle of a frame discards the bytes already taken, and the next byte accepted after reset is byte 0 of a new frame.
- R2: A byte is taken in a cycle where inValid and inReady are both high. The k-th byte taken in a frame (k counted from 0) appears at outFrame[8k+7:8k].
- R3: A frame is HDR_BYTES header bytes (indices 0 to HDR_BYTES-1), then PAY_BYTES payload bytes, then CHK_W/8 check bytes. The check field is sent low byte first, so only the byte at index HDR_BYTES+PAY_BYTES takes part in the comparison.
- R4: The expected check is the XOR of the header bytes only. Payload bytes and the upper check bytes have no effect on the outcome.
- R5: On a match, outValid is 1 in the cycle after the last byte is taken, and outFrame holds the complete frame.
- R6: On a mismatch, badPulse is 1 for exactly one cycle, the cycle after the last byte is taken. outValid stays 0 for that frame.
- R7: While outValid is 1 and outReady is 0, outValid and outFrame hold, and inReady is 0. The frame is consumed at the clock edge where outValid and outReady are both 1.
- R8: The header XOR restarts with every frame, so the outcome of a frame does not depend on any earlier frame.
- R9: Collection overlaps with reporting. inReady is 1 in the cycle badPulse is shown, and also in any cycle where outReady is 1. The first byte of the next frame can therefore be taken in either of those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte is present |
| inReady | output | 1 | Block can take a byte this cycle |
| inData | input | 8 | Input byte |
| outValid | output | 1 | A checked frame is on outFrame |
| outReady | input | 1 | Consumer takes the frame |
| outFrame | output | 8*(HDR_BYTES+PAY_BYTES+CHK_W/8) | Frame, byte k at bits 8k+7:8k |
| badPulse | output | 1 | One-cycle check failure indication |

## Verification
Two things can happen in the same cycle: the error pulse of one frame, and the acceptance of the first byte of the next frame. The same is true of a good frame being consumed and the next byte being taken. The bench drives frames back to back with no idle cycles, so every result is reported while the following frame's first byte is already on the input. It then checks that the pulse and the output frame are correct, that the pulse is gone one cycle later, and that the next frame's outcome is unaffected. A sweep over all 256 check bytes for a fixed header confirms that exactly one value passes. A second sweep varies the header, payload and upper check byte.

// File: rtl/frame_checker_pkg.sv
package frame_checker_pkg;
  typedef struct packed {
    logic accept;  // byte taken this cycle
    logic first;   // taken byte is index 0
    logic last;    // taken byte completes the frame
    logic load;    // commit frame to output register
  } fcStrobe_t;
endpackage

// File: rtl/fc_datapath.sv
module fc_datapath
  import frame_checker_pkg::*;
#(
  parameter int HDR_BYTES = 4,
  parameter int PAY_BYTES = 3,
  parameter int CHK_W     = 16,
  localparam int CHK_BYTES   = CHK_W / 8,
  localparam int FRAME_BYTES = HDR_BYTES + PAY_BYTES + CHK_BYTES,
  localparam int IDX_W       = $clog2(FRAME_BYTES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  fcStrobe_t                st,
  input  logic [IDX_W-1:0]         idx,
  input  logic [7:0]               inData,
  output logic                     match,
  output logic [FRAME_BYTES*8-1:0] outFrame
);
  localparam logic [IDX_W-1:0] CHK_POS = IDX_W'(HDR_BYTES + PAY_BYTES);
  localparam logic [IDX_W-1:0] HDR_END = IDX_W'(HDR_BYTES);

  logic [FRAME_BYTES*8-1:0] frameBuf, frameNext;
  logic [7:0] hdrAcc, chkLow, chkNow;

  always_comb begin
    frameNext = frameBuf;
    frameNext[idx*8 +: 8] = inData;
  end

  // check byte bypass covers the case where it is the final byte
  assign chkNow = (idx == CHK_POS) ? inData : chkLow;
  assign match  = (chkNow == hdrAcc);

  always_ff @(posedge clk) begin
    if (rst) begin
      frameBuf <= '0;
      outFrame <= '0;
      hdrAcc   <= '0;
      chkLow   <= '0;
    end else begin
      if (st.accept) begin
        frameBuf <= frameNext;
        if (idx < HDR_END) hdrAcc <= st.first ? inData : (hdrAcc ^ inData);
        if (idx == CHK_POS) chkLow <= inData;
      end
      if (st.load) outFrame <= frameNext;
    end
  end

  // R8
  acc_restart_chk: assert property (@(posedge clk) disable iff (rst)
    st.first |=> (hdrAcc == $past(inData)));
endmodule

// File: rtl/fc_control.sv
module fc_control
  import frame_checker_pkg::*;
#(
  parameter int FRAME_BYTES = 9,
  localparam int IDX_W = $clog2(FRAME_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             outReady,
  input  logic             match,
  output logic             inReady,
  output logic             outValid,
  output logic             badPulse,
  output logic [IDX_W-1:0] idx,
  output fcStrobe_t        st
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  assign inReady   = !outValid || outReady;
  assign st.accept = inValid && inReady;
  assign st.first  = st.accept && (idx == '0);
  assign st.last   = st.accept && (idx == LAST_IDX);
  assign st.load   = st.last && match;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      outValid <= 1'b0;
      badPulse <= 1'b0;
    end else begin
      if (st.accept) idx <= st.last ? '0 : idx + 1'b1;
      if (st.load) outValid <= 1'b1;
      else if (outReady) outValid <= 1'b0;
      badPulse <= st.last && !match;
    end
  end

  // R6
  bad_single_chk: assert property (@(posedge clk) disable iff (rst)
    badPulse |=> !badPulse);
  // R6
  bad_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(badPulse && $rose(outValid)));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> outValid);
  // R9
  bad_frame_end_chk: assert property (@(posedge clk) disable iff (rst)
    badPulse |-> (idx == '0 || idx == 1) && inReady);
endmodule

// File: rtl/frame_checker.sv
module frame_checker
  import frame_checker_pkg::*;
#(
  parameter int HDR_BYTES = 4,
  parameter int PAY_BYTES = 3,
  parameter int CHK_W     = 16,
  localparam int FRAME_BYTES = HDR_BYTES + PAY_BYTES + CHK_W / 8,
  localparam int IDX_W       = $clog2(FRAME_BYTES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [7:0]               inData,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [FRAME_BYTES*8-1:0] outFrame,
  output logic                     badPulse
);
  fcStrobe_t        st;
  logic [IDX_W-1:0] idx;
  logic             match;

  fc_control #(.FRAME_BYTES(FRAME_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .match(match), .inReady(inReady), .outValid(outValid),
    .badPulse(badPulse), .idx(idx), .st(st)
  );

  fc_datapath #(.HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES), .CHK_W(CHK_W)) u_dp (
    .clk(clk), .rst(rst), .st(st), .idx(idx), .inData(inData),
    .match(match), .outFrame(outFrame)
  );
endmodule

// File: tb/test_frame_checker.sv
module test_frame_checker;
  localparam int HB = 4, PB = 3, CW = 16;
  localparam int FB = HB + PB + CW / 8;
  localparam int CP = HB + PB;

  logic clk = 0, rst = 1, inValid = 0, outReady = 1;
  logic [7:0] inData = '0;
  logic inReady, outValid, badPulse;
  logic [FB*8-1:0] outFrame;

  int nRun = 0, nFail = 0;
  bit done = 0;
  logic [7:0] fr [FB];

  always #2 clk = ~clk;

  frame_checker #(.HDR_BYTES(HB), .PAY_BYTES(PB), .CHK_W(CW)) i_frame_checker (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outFrame(outFrame), .badPulse(badPulse)
  );

  task automatic check(input string req, input logic [FB*8-1:0] act, input logic [FB*8-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FB*8-1:0] packFrame();
    logic [FB*8-1:0] p;
    for (int k = 0; k < FB; k++) p[k*8 +: 8] = fr[k];
    return p;
  endfunction

  function automatic logic [7:0] hdrXor();
    logic [7:0] x = '0;
    for (int k = 0; k < HB; k++) x ^= fr[k];
    return x;
  endfunction

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk); inValid = 1; inData = b;
    while (!inReady) @(negedge clk);
    @(posedge clk); #1;
    inValid = 0;
  endtask

  // push fr[] back to back and judge the outcome one cycle after the last byte
  task automatic runFrame(input string req);
    logic good;
    good = (fr[CP] == hdrXor());
    for (int k = 0; k < FB; k++) begin
      pushByte(fr[k]);
      // R9 R6: the previous result has cleared once the next frame's first byte is in
      if (k == 0 && outReady) check("R6/R9 clear", {outValid, badPulse}, 0);
    end
    check({req, " R5/R6 outcome"}, {outValid, badPulse}, good ? 2'b10 : 2'b01);
    if (good) check({req, " R2/R5 frame"}, outFrame, packFrame());
    else check("R9 inReady during badPulse", inReady, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check("R1 reset state", {inReady, outValid, badPulse}, 3'b100);

    // R3 R4: sweep every low check byte under a fixed header; exactly one passes
    fr[0] = 8'h3C; fr[1] = 8'hA5; fr[2] = 8'h0F; fr[3] = 8'h71;
    for (int c = 0; c < 256; c++) begin
      for (int k = HB; k < CP; k++) fr[k] = 8'((c * 3 + k * 29) & 8'hFF);
      fr[CP] = 8'(c);
      fr[CP + 1] = 8'(c) ^ 8'h5A;
      runFrame("R3/R4 chk sweep");
    end

    // R4 R8: header, payload and upper check byte varied; alternate good/bad
    for (int n = 0; n < 64; n++) begin
      for (int k = 0; k < FB; k++) fr[k] = 8'((n * 37 + k * 11 + k * k) & 8'hFF);
      fr[CP] = hdrXor() ^ ((n % 2 == 1) ? 8'(1 << (n % 8)) : 8'h00);
      runFrame("R4/R8 hdr sweep");
    end

    // R7: backpressure holds the frame and stalls input
    outReady = 0;
    for (int k = 0; k < FB; k++) fr[k] = 8'(8'hC0 + k);
    fr[CP] = hdrXor();
    runFrame("R7 bp");
    begin
      logic [FB*8-1:0] held;
      held = outFrame;
      check("R7 inReady low", inReady, 0);
      @(negedge clk); inValid = 1; inData = 8'hEE;
      for (int t = 0; t < 5; t++) begin
        @(negedge clk);
        check("R7 hold", {outValid, inReady, outFrame}, {2'b10, held});
      end
      inValid = 0; outReady = 1;
      @(negedge clk);
      check("R7 consumed", outValid, 0);
    end

    // R1: reset in the middle of a frame
    pushByte(8'h11); pushByte(8'h22); pushByte(8'h33);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 mid reset", {inReady, outValid, badPulse}, 3'b100);
    for (int k = 0; k < FB; k++) fr[k] = 8'(8'h80 ^ (k * 19));
    fr[CP] = hdrXor();
    runFrame("R1 after reset");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule